// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address into a physical address. A logical address has two parts: a segment number and an offset within that segment. A small on-chip table has one entry for each possible segment number. Each entry holds a physical base address, a segment length, a valid flag and three access-right flags (read, write, execute). A separate length register sets how many segments are legal, counting up from segment 0.

For each request the block runs four legality checks in a fixed order:
1. The segment number is tested against the length register.
2. The entry's valid flag is tested.
3. The offset is tested against the entry's length.
4. The requested access kind is tested against the entry's rights.

If every check passes, the block returns base plus offset. Otherwise it returns a trap with a code that names the first check that failed. The table and the length register are loaded through dedicated write ports. The response is registered and appears one cycle after the request.

Top module: `segXlate`

## Requirements
- R1: After reset every table entry has its valid flag cleared and the length register is 0. `rspValid` is low, and the first request traps with cause 1.
- R2: A request presented with `reqValid` high in one cycle gives `rspValid` high in the next cycle. A cycle without a request gives `rspValid` low and `rspTrap` low in the next cycle.
- R3: A segment number greater than or equal to the length register traps with cause 1 (segment out of range). The length register is `SEG_W+1` bits wide, so a value of 2^SEG_W makes every segment number legal.
- R4: A segment whose entry has its valid flag at 0 traps with cause 2 (segment not valid).
- R5: An offset greater than or equal to the entry's length traps with cause 3 (offset beyond length). The length field is `OFF_W+1` bits wide, so a length of 2^OFF_W admits every offset.
- R6: Access kinds are encoded as 0 = read, 1 = write and 2 = execute. They need the entry's rights bit 0, bit 1 and bit 2 respectively. Kind 3 is never permitted. A denied access traps with cause 4 (access denied).
- R7: When several checks fail at once, the reported cause is the first failing check in this order: range, valid, length, rights.
- R8: When every check passes, the response has `rspTrap` low and cause 0. `rspAddr` is the entry base plus the zero-extended offset, modulo 2^PA_W.
- R9: A trapping response drives `rspAddr` to 0.
- R10: A table write or length write applies to requests from the following cycle onward. A request in the same cycle as a write is judged against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tblWrEn | input | 1 | Table entry write strobe |
| tblWrIdx | input | SEG_W | Entry to write |
| tblWrBase | input | PA_W | Physical base address of the entry |
| tblWrLimit | input | OFF_W+1 | Segment length in address units |
| tblWrValid | input | 1 | Valid flag of the entry |
| tblWrPerm | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| lenWrEn | input | 1 | Length register write strobe |
| lenWrVal | input | SEG_W+1 | New count of legal segments |
| reqValid | input | 1 | Translation request strobe |
| reqSeg | input | SEG_W | Segment number |
| reqOff | input | OFF_W | Offset within segment |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rspValid | output | 1 | Response present |
| rspTrap | output | 1 | Translation refused |
| rspCause | output | 3 | 0 ok, 1 range, 2 not valid, 3 beyond length, 4 access denied |
| rspAddr | output | PA_W | Physical address, 0 on trap |

## Verification
The checker enforces several rules on every cycle:
- the one-cycle request-to-response relation;
- a zero address on every trap;
- a clean cause code on every success;
- the out-of-range trap, derived from the length register;
- the beyond-length trap, derived from the looked-up entry.

Some behaviour can only be shown by the bench's scenarios, because it depends on table contents that the bench sets up:
- the priority order when several checks fail together;
- the per-kind rights decoding;
- wrap-around of the base-plus-offset sum;
- the rule that a write does not affect a request in the same cycle.

The bench also runs a long randomized run that mixes table writes, length writes and requests against a reference model.

// File: rtl/segx_pkg.sv
package segx_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_t;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_SEGRANGE = 3'd1,
    CAUSE_INVALID  = 3'd2,
    CAUSE_LIMIT    = 3'd3,
    CAUSE_PERM     = 3'd4
  } cause_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   rspLoad;
    logic   trap;
    cause_t cause;
  } ctrlStrobe_t;

endpackage

// File: rtl/segx_datapath.sv
module segx_datapath
  import segx_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tblWrEn,
  input  logic [SEG_W-1:0]   tblWrIdx,
  input  logic [PA_W-1:0]    tblWrBase,
  input  logic [OFF_W:0]     tblWrLimit,
  input  logic               tblWrValid,
  input  logic [2:0]         tblWrPerm,
  input  logic               lenWrEn,
  input  logic [SEG_W:0]     lenWrVal,
  input  logic [SEG_W-1:0]   reqSeg,
  input  logic [OFF_W-1:0]   reqOff,
  input  ctrlStrobe_t        strobe,
  output logic [SEG_W:0]     lenQ,
  output logic               entValid,
  output logic [OFF_W:0]     entLimit,
  output logic [2:0]         entPerm,
  output logic               rspValid,
  output logic               rspTrap,
  output logic [2:0]         rspCause,
  output logic [PA_W-1:0]    rspAddr
);

  localparam int NUM_ENT = 1 << SEG_W;
  localparam int LIM_W   = OFF_W + 1;
  localparam int ENT_W   = PA_W + LIM_W + 1 + 3;

  logic [ENT_W-1:0] entMem [NUM_ENT];
  logic [ENT_W-1:0] entSel;
  logic [PA_W-1:0]  entBase;
  logic [PA_W-1:0]  sumAddr;

  // one storage word per segment; written whole
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entMem[g] <= '0;
      end else if (tblWrEn && (tblWrIdx == SEG_W'(g))) begin
        entMem[g] <= {tblWrBase, tblWrLimit, tblWrValid, tblWrPerm};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ <= '0;
    end else if (lenWrEn) begin
      lenQ <= lenWrVal;
    end
  end

  // lookup reads pre-write contents
  assign entSel   = entMem[reqSeg];
  assign entBase  = entSel[ENT_W-1 -: PA_W];
  assign entLimit = entSel[3+1 +: LIM_W];
  assign entValid = entSel[3];
  assign entPerm  = entSel[2:0];

  assign sumAddr = entBase + PA_W'(reqOff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspTrap  <= 1'b0;
      rspCause <= '0;
      rspAddr  <= '0;
    end else if (strobe.rspLoad) begin
      rspValid <= 1'b1;
      rspTrap  <= strobe.trap;
      rspCause <= strobe.cause;
      rspAddr  <= strobe.trap ? '0 : sumAddr;
    end else begin
      rspValid <= 1'b0;
      rspTrap  <= 1'b0;
      rspCause <= '0;
      rspAddr  <= '0;
    end
  end

endmodule

// File: rtl/segx_ctrl.sv
module segx_ctrl
  import segx_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12
) (
  input  logic               reqValid,
  input  logic [SEG_W-1:0]   reqSeg,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic [1:0]         reqKind,
  input  logic [SEG_W:0]     lenQ,
  input  logic               entValid,
  input  logic [OFF_W:0]     entLimit,
  input  logic [2:0]         entPerm,
  output ctrlStrobe_t        strobe
);

  logic segBad, offBad, permOk;

  assign segBad = ({1'b0, reqSeg} >= lenQ);
  assign offBad = ({1'b0, reqOff} >= entLimit);

  always_comb begin
    unique case (accKind_t'(reqKind))
      ACC_READ:  permOk = entPerm[0];
      ACC_WRITE: permOk = entPerm[1];
      ACC_EXEC:  permOk = entPerm[2];
      default:   permOk = 1'b0;
    endcase
  end

  // fixed priority: range, valid, length, rights
  always_comb begin
    strobe.rspLoad = reqValid;
    if (segBad)         strobe.cause = CAUSE_SEGRANGE;
    else if (!entValid) strobe.cause = CAUSE_INVALID;
    else if (offBad)    strobe.cause = CAUSE_LIMIT;
    else if (!permOk)   strobe.cause = CAUSE_PERM;
    else                strobe.cause = CAUSE_NONE;
    strobe.trap = (strobe.cause != CAUSE_NONE);
  end

endmodule

// File: rtl/segXlate.sv
module segXlate
  import segx_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tblWrEn,
  input  logic [SEG_W-1:0]   tblWrIdx,
  input  logic [PA_W-1:0]    tblWrBase,
  input  logic [OFF_W:0]     tblWrLimit,
  input  logic               tblWrValid,
  input  logic [2:0]         tblWrPerm,
  input  logic               lenWrEn,
  input  logic [SEG_W:0]     lenWrVal,
  input  logic               reqValid,
  input  logic [SEG_W-1:0]   reqSeg,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic [1:0]         reqKind,
  output logic               rspValid,
  output logic               rspTrap,
  output logic [2:0]         rspCause,
  output logic [PA_W-1:0]    rspAddr
);

  ctrlStrobe_t        strobe;
  logic [SEG_W:0]     lenQ;
  logic               entValid;
  logic [OFF_W:0]     entLimit;
  logic [2:0]         entPerm;

  segx_ctrl #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_ctrl (
    .reqValid (reqValid),
    .reqSeg   (reqSeg),
    .reqOff   (reqOff),
    .reqKind  (reqKind),
    .lenQ     (lenQ),
    .entValid (entValid),
    .entLimit (entLimit),
    .entPerm  (entPerm),
    .strobe   (strobe)
  );

  segx_datapath #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tblWrEn    (tblWrEn),
    .tblWrIdx   (tblWrIdx),
    .tblWrBase  (tblWrBase),
    .tblWrLimit (tblWrLimit),
    .tblWrValid (tblWrValid),
    .tblWrPerm  (tblWrPerm),
    .lenWrEn    (lenWrEn),
    .lenWrVal   (lenWrVal),
    .reqSeg     (reqSeg),
    .reqOff     (reqOff),
    .strobe     (strobe),
    .lenQ       (lenQ),
    .entValid   (entValid),
    .entLimit   (entLimit),
    .entPerm    (entPerm),
    .rspValid   (rspValid),
    .rspTrap    (rspTrap),
    .rspCause   (rspCause),
    .rspAddr    (rspAddr)
  );

endmodule

// File: rtl/segx_checker.sv
module segx_checker #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [SEG_W-1:0] reqSeg,
  input logic [OFF_W-1:0] reqOff,
  input logic [SEG_W:0]   lenQ,
  input logic [OFF_W:0]   entLimit,
  input logic             rspValid,
  input logic             rspTrap,
  input logic [2:0]       rspCause,
  input logic [PA_W-1:0]  rspAddr
);

  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r2_no_resp_without_req: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspTrap));

  a_r3_seg_range_trap: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ({1'b0, reqSeg} >= lenQ)) |=> (rspTrap && rspCause == 3'd1));

  a_r5_beyond_length_trap: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ({1'b0, reqOff} >= entLimit)) |=> rspTrap);

  a_r8_clean_cause: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspTrap) |-> (rspCause == 3'd0));

  a_r9_zero_addr_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspTrap) |-> (rspAddr == '0));

  a_r7_cause_in_range: assert property (@(posedge clk) disable iff (!rstN)
    rspTrap |-> (rspCause >= 3'd1 && rspCause <= 3'd4));

endmodule

bind segXlate segx_checker #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqSeg   (reqSeg),
  .reqOff   (reqOff),
  .lenQ     (lenQ),
  .entLimit (entLimit),
  .rspValid (rspValid),
  .rspTrap  (rspTrap),
  .rspCause (rspCause),
  .rspAddr  (rspAddr)
);

// File: tb/test_segXlate.sv
module test_segXlate;
  localparam int SEG_W = 4;
  localparam int OFF_W = 12;
  localparam int PA_W  = 20;
  localparam int NENT  = 1 << SEG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tblWrEn = 0;
  logic [SEG_W-1:0] tblWrIdx = '0;
  logic [PA_W-1:0] tblWrBase = '0;
  logic [OFF_W:0] tblWrLimit = '0;
  logic tblWrValid = 0;
  logic [2:0] tblWrPerm = '0;
  logic lenWrEn = 0;
  logic [SEG_W:0] lenWrVal = '0;
  logic reqValid = 0;
  logic [SEG_W-1:0] reqSeg = '0;
  logic [OFF_W-1:0] reqOff = '0;
  logic [1:0] reqKind = '0;
  logic rspValid, rspTrap;
  logic [2:0] rspCause;
  logic [PA_W-1:0] rspAddr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [PA_W-1:0] mBase [NENT];
  logic [OFF_W:0]  mLim  [NENT];
  logic            mVal  [NENT];
  logic [2:0]      mPerm [NENT];
  logic [SEG_W:0]  mLen;

  always #2.5 clk = ~clk;

  segXlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_segXlate (
    .clk(clk), .rstN(rstN), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
    .tblWrBase(tblWrBase), .tblWrLimit(tblWrLimit), .tblWrValid(tblWrValid),
    .tblWrPerm(tblWrPerm), .lenWrEn(lenWrEn), .lenWrVal(lenWrVal),
    .reqValid(reqValid), .reqSeg(reqSeg), .reqOff(reqOff), .reqKind(reqKind),
    .rspValid(rspValid), .rspTrap(rspTrap), .rspCause(rspCause), .rspAddr(rspAddr));

  // reference cause from the requirement order (R3, R4, R5, R6, R7)
  function automatic logic [2:0] expCause(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o,
                                          input logic [1:0] k);
    logic ok;
    if ({1'b0, s} >= mLen) return 3'd1;
    if (!mVal[s]) return 3'd2;
    if ({1'b0, o} >= mLim[s]) return 3'd3;
    ok = (k == 2'd3) ? 1'b0 : mPerm[s][k];
    if (!ok) return 3'd4;
    return 3'd0;
  endfunction

  task automatic step(input string tag);
    logic eV, eT; logic [2:0] eC; logic [PA_W-1:0] eA;
    eV = reqValid;
    eC = reqValid ? expCause(reqSeg, reqOff, reqKind) : 3'd0;
    eT = eV && (eC != 3'd0);
    eA = (eV && !eT) ? mBase[reqSeg] + PA_W'(reqOff) : '0;
    if (tblWrEn) begin
      mBase[tblWrIdx] = tblWrBase; mLim[tblWrIdx] = tblWrLimit;
      mVal[tblWrIdx] = tblWrValid; mPerm[tblWrIdx] = tblWrPerm;
    end
    if (lenWrEn) mLen = lenWrVal;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rspValid !== eV || rspTrap !== eT || rspCause !== eC || rspAddr !== eA) begin
      failures++;
      $display("FAIL %s: got v=%0b t=%0b c=%0d a=%h exp v=%0b t=%0b c=%0d a=%h",
               tag, rspValid, rspTrap, rspCause, rspAddr, eV, eT, eC, eA);
    end
    tblWrEn = 0; lenWrEn = 0; reqValid = 0;
  endtask

  task automatic wrEnt(input int idx, input logic [PA_W-1:0] b, input logic [OFF_W:0] l,
                       input logic v, input logic [2:0] p);
    tblWrEn = 1; tblWrIdx = SEG_W'(idx); tblWrBase = b; tblWrLimit = l;
    tblWrValid = v; tblWrPerm = p;
  endtask

  task automatic rq(input int s, input int o, input int k);
    reqValid = 1; reqSeg = SEG_W'(s); reqOff = OFF_W'(o); reqKind = 2'(k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5E61));
    for (int i = 0; i < NENT; i++) begin
      mBase[i] = '0; mLim[i] = '0; mVal[i] = 0; mPerm[i] = '0;
    end
    mLen = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) begin
      failures++; $display("FAIL R1: got rspValid=%0b exp 0", rspValid);
    end
    rq(0, 0, 0); step("R1 first request out of range");
    step("R2 idle cycle");
    // setup
    lenWrEn = 1; lenWrVal = 5'd4; step("R2 idle with len write");
    wrEnt(1, 20'h10000, 13'h100, 1, 3'b011); step("R2 idle with table write");
    rq(1, 'hFF, 0); step("R8 read at last offset");
    rq(1, 'h100, 1); step("R5 offset equals length");
    rq(1, 'h10, 2); step("R6 exec denied");
    rq(1, 'h10, 3); step("R6 kind 3 denied");
    rq(1, 'h10, 1); step("R6 write allowed R8");
    rq(4, 0, 0); step("R3 seg equals length");
    rq(3, 0, 0); step("R4 untouched entry not valid");
    // priority R7
    wrEnt(2, 20'h3, 13'h0, 0, 3'b000); step("R2 idle");
    rq(2, 'h5, 2); step("R7 invalid before length/rights");
    wrEnt(5, 20'h0, 13'h0, 0, 3'b000); step("R2 idle");
    rq(5, 'h5, 3); step("R7 range before everything");
    lenWrEn = 1; lenWrVal = 5'd8; wrEnt(6, 20'h2000, 13'h10, 1, 3'b000); step("R2 idle");
    rq(6, 'h20, 0); step("R7 length before rights");
    rq(6, 'h2, 0); step("R7 rights last");
    // R10 same-cycle write
    wrEnt(7, 20'h40000, 13'h1000, 1, 3'b111); rq(7, 'hFFF, 2);
    step("R10 same-cycle write not seen");
    rq(7, 'hFFF, 2); step("R10 write seen next cycle R5 full length");
    lenWrEn = 1; lenWrVal = 5'd16; rq(9, 0, 0); step("R10 len write not seen same cycle");
    rq(9, 0, 0); step("R10 len 16 admits seg 9 R4");
    // R8 wrap
    wrEnt(15, 20'hFFFF0, 13'h1000, 1, 3'b001); step("R2 idle");
    rq(15, 'h20, 0); step("R8 base plus offset wraps");
    rq(15, 'hFFF, 0); step("R8 top offset wrap");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 20) wrEnt($urandom_range(0, NENT-1), PA_W'($urandom),
                        13'($urandom_range(0, 4096)), 1'($urandom_range(0, 3) != 0),
                        3'($urandom));
      if (r >= 95) begin lenWrEn = 1; lenWrVal = 5'($urandom_range(0, 20)); end
      if ($urandom_range(0, 9) < 8)
        rq($urandom_range(0, NENT-1), $urandom_range(0, 4095), $urandom_range(0, 3));
      step("R8 R7 random mix");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule